// File: doc/BRIEF.md
# Prescaled Periodic Tick Timer

The block produces a periodic interrupt from a 15-bit counting chain: an 8-stage binary divider whose carry advances a 7-bit prescaler. The chain advances on source ticks. A static option picks the source: either an already-synchronized real-time oscillator tick, or an instruction-rate tick made inside the block by dividing the system clock by 4. A 3-bit rate code chooses how many low chain bits must all be ones at a tick for a timeout. Code k gives a period of 2^(8+k) source ticks. Codes 0 to 3 are legal but give short periods.

A timeout sets two flags, but only when the timer source enable is on. One is a request flag for this source. The other is a flag shared by all multi-function interrupt sources. Both flags stay set until software writes zero to them. When the shared flag goes from clear to set, the block asks for a call to vector 0x18. It does this only if the multi-function interrupt enable is on and the stack-full input is low. The interrupt controller and the stack are represented only by these ports.

Two further outputs bring out divider stages, each chosen by its own static option. They can serve as fixed-frequency clocks for a display driver and for a buzzer. Registers are reached over a simple single-cycle write bus with a combinational read port.

Top module: `ptick_timer`

## Requirements
- R1: After reset, every register reads 0x00 and vec_req is low.
- R2: With src_rtc low, the chain advances once every 4 system clocks. After a rate write of code 0, the first vec_req appears exactly 1024 clock edges after the write edge.
- R3: With src_rtc high, each clock with rtc_tick high is one source tick. For every rate code k (0 to 7) written to address 0 bits 2..0, a timeout occurs on source tick 2^(8+k) counted from the write.
- R4: A write to address 0 clears the whole chain and the internal divide-by-4 phase. The first period after the write therefore has the full new length, whatever count was reached before.
- R5: A timeout sets two flags when the timer enable (address 1 bit 0) is 1: the source flag (address 1 bit 1) and the shared flag (address 2 bit 6). When the timer enable is 0, a timeout sets neither flag.
- R6: Both flags are sticky. Writing 0 to a flag's bit clears it, and writing 1 to it has no effect. If a timeout and a clearing write fall on the same edge, the flag stays set.
- R7: vec_req is a one-cycle pulse, with vec_addr equal to 0x18, in the cycle after the shared flag goes from 0 to 1. It is not raised again while that flag stays set.
- R8: No vec_req is raised when the multi-function enable (address 2 bit 0) is 0 or when stack_full is high at the timeout edge. The flags are still set.
- R9: After a rate write followed by n consecutive source ticks, disp_out equals bit disp_sel of n and bz_out equals bit bz_sel of n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_rtc | input | 1 | Static option: 1 selects rtc_tick as the source, 0 selects system clock divided by 4 |
| rtc_tick | input | 1 | Synchronous real-time oscillator tick enable |
| disp_sel | input | 3 | Static option: divider stage driven to disp_out |
| bz_sel | input | 3 | Static option: divider stage driven to bz_out |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 rate, 1 status, 2 control |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Combinational read data for reg_addr |
| stack_full | input | 1 | High when the call stack has no room |
| vec_req | output | 1 | One-cycle request for an interrupt call |
| vec_addr | output | 8 | Vector address that goes with vec_req |
| disp_out | output | 1 | Divider tap for a display driver |
| bz_out | output | 1 | Divider tap for a buzzer |

## Verification
The assertions assume that every input is synchronous to clk, that rtc_tick is a clock enable and not a raw oscillator edge, and that address and data are known whenever reg_we is high. The stimulus changes every input only on the falling edge. It drives rtc_tick itself as runs of consecutive high cycles, so the number of source ticks since each rate write is exact. The static options src_rtc, disp_sel and bz_sel change only while the chain is idle, and a rate write that realigns the chain follows each change.

// File: rtl/ptick_timer.sv
module ptick_timer #(
  parameter int DIV_BITS = 8,
  parameter int PRE_BITS = 7,
  parameter int SEL_W    = 3,
  parameter int DATA_W   = 8,
  parameter logic [7:0] VECTOR = 8'h18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              src_rtc,
  input  logic              rtc_tick,
  input  logic [SEL_W-1:0]  disp_sel,
  input  logic [SEL_W-1:0]  bz_sel,
  input  logic              reg_we,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              stack_full,
  output logic              vec_req,
  output logic [7:0]        vec_addr,
  output logic              disp_out,
  output logic              bz_out
);
  localparam int CHAIN = DIV_BITS + PRE_BITS;
  localparam int EN_BIT = 0;
  localparam int SRC_FLAG_BIT = 1;
  localparam int MF_FLAG_BIT = 6;

  logic [1:0]       icyc;
  logic [CHAIN-1:0] chain, span_mask;
  logic [SEL_W-1:0] rate;
  logic tmr_en, src_flag, mf_en, mf_flag, vec_q;
  logic tick, timeout, fire;

  wire wr_rate = reg_we && reg_addr == 2'd0;
  wire wr_stat = reg_we && reg_addr == 2'd1;
  wire wr_ctl  = reg_we && reg_addr == 2'd2;

  assign tick = src_rtc ? rtc_tick : (icyc == 2'd3);

  always_comb
    for (int i = 0; i < CHAIN; i++)
      span_mask[i] = (i < DIV_BITS + int'(rate));

  assign timeout = tick && ((chain & span_mask) == span_mask);
  assign fire    = timeout && tmr_en;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      icyc  <= '0;
      chain <= '0;
      rate  <= '0;
    end else if (wr_rate) begin
      icyc  <= '0;
      chain <= '0;
      rate  <= reg_wdata[SEL_W-1:0];
    end else begin
      icyc <= icyc + 2'd1;
      if (tick) chain <= chain + 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tmr_en   <= 1'b0;
      mf_en    <= 1'b0;
      src_flag <= 1'b0;
      mf_flag  <= 1'b0;
      vec_q    <= 1'b0;
    end else begin
      if (wr_stat) tmr_en <= reg_wdata[EN_BIT];
      if (wr_ctl)  mf_en  <= reg_wdata[EN_BIT];
      src_flag <= fire | (src_flag & ~(wr_stat & ~reg_wdata[SRC_FLAG_BIT]));
      mf_flag  <= fire | (mf_flag  & ~(wr_ctl  & ~reg_wdata[MF_FLAG_BIT]));
      vec_q    <= fire & ~mf_flag & mf_en & ~stack_full;
    end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      2'd0: reg_rdata[SEL_W-1:0] = rate;
      2'd1: begin
        reg_rdata[EN_BIT]       = tmr_en;
        reg_rdata[SRC_FLAG_BIT] = src_flag;
      end
      2'd2: begin
        reg_rdata[EN_BIT]      = mf_en;
        reg_rdata[MF_FLAG_BIT] = mf_flag;
      end
      default: reg_rdata = '0;
    endcase
  end

  assign vec_req  = vec_q;
  assign vec_addr = VECTOR;
  assign disp_out = chain[disp_sel];
  assign bz_out   = chain[bz_sel];
endmodule

module ptick_timer_chk #(
  parameter int DATA_W = 8,
  parameter logic [7:0] VECTOR = 8'h18
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_we,
  input logic [1:0]        reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic              stack_full,
  input logic              vec_req,
  input logic [7:0]        vec_addr,
  input logic              tmr_en,
  input logic              src_flag,
  input logic              mf_en,
  input logic              mf_flag
);
  a_in_known: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> !$isunknown({reg_addr, reg_wdata}));
  a_r5_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(src_flag) |-> $past(tmr_en));
  a_r5_both_flags: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(src_flag) |-> mf_flag);
  a_r6_src_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(src_flag) |-> $past(reg_we && reg_addr == 2'd1 && !reg_wdata[1]));
  a_r6_mf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mf_flag) |-> $past(reg_we && reg_addr == 2'd2 && !reg_wdata[6]));
  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    vec_req |=> !vec_req);
  a_r7_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    vec_req |-> $rose(mf_flag));
  a_r7_vector: assert property (@(posedge clk) disable iff (!rst_n)
    vec_req |-> vec_addr == VECTOR);
  a_r8_gated: assert property (@(posedge clk) disable iff (!rst_n)
    vec_req |-> ($past(mf_en) && !$past(stack_full)));
endmodule

bind ptick_timer ptick_timer_chk #(.DATA_W(DATA_W), .VECTOR(VECTOR)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .stack_full(stack_full), .vec_req(vec_req),
  .vec_addr(vec_addr), .tmr_en(tmr_en), .src_flag(src_flag),
  .mf_en(mf_en), .mf_flag(mf_flag)
);

// File: tb/tb_ptick_timer.sv
`timescale 1ns/1ps
module tb_ptick_timer;
  logic clk = 0, rst_n = 0, src_rtc = 1, rtc_tick = 0, reg_we = 0, stack_full = 0;
  logic [1:0] reg_addr = 0;
  logic [7:0] reg_wdata = 0;
  logic [2:0] disp_sel = 0, bz_sel = 0;
  logic [7:0] reg_rdata, vec_addr;
  logic vec_req, disp_out, bz_out;
  int checks = 0, errors = 0, since_sel = 0, vec_seen = 0, vec_pushed = 0;
  int exp_q[$];
  bit done = 0;

  always #4 clk = ~clk;

  ptick_timer dut (.clk(clk), .rst_n(rst_n), .src_rtc(src_rtc), .rtc_tick(rtc_tick),
    .disp_sel(disp_sel), .bz_sel(bz_sel), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .stack_full(stack_full),
    .vec_req(vec_req), .vec_addr(vec_addr), .disp_out(disp_out), .bz_out(bz_out));

  always @(posedge clk)
    if (reg_we && reg_addr == 2'd0) since_sel <= 0;
    else since_sel <= since_sel + 1;

  // monitor: scoreboard side (R7)
  always @(negedge clk)
    if (rst_n && vec_req) begin
      int e;
      vec_seen++;
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R7: vec_req at %0d cycles after rate write, expected none", since_sel);
      end else begin
        e = exp_q.pop_front();
        if (e != since_sel || vec_addr != 8'h18) begin
          errors++;
          $display("FAIL R3/R7: vec_req at %0d addr %h, expected %0d addr 18", since_sel, vec_addr, e);
        end
      end
    end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic rd(input logic [1:0] a, output int v);
    reg_addr = a;
    #1 v = reg_rdata;
  endtask

  task automatic ticks(int n);
    rtc_tick = 1;
    repeat (n) @(negedge clk);
    rtc_tick = 0;
  endtask

  task automatic expect_vec(int at);
    exp_q.push_back(at);
    vec_pushed++;
  endtask

  task automatic settle_clear(string tag, int stat_exp, int ctl_exp, logic [7:0] stat_w, logic [7:0] ctl_w);
    int v;
    repeat (2) @(negedge clk);
    rd(2'd1, v); chk({tag, " status"}, v, stat_exp);
    rd(2'd2, v); chk({tag, " control"}, v, ctl_exp);
    wr(2'd1, stat_w);
    wr(2'd2, ctl_w);
  endtask

  initial begin
    int v;
    repeat (3) @(negedge clk);
    rd(2'd0, v); chk("R1 rate reset", v, 0);
    rd(2'd1, v); chk("R1 status reset", v, 0);
    rd(2'd2, v); chk("R1 control reset", v, 0);
    chk("R1 vec_req reset", vec_req, 0);
    rst_n = 1;
    @(negedge clk);

    wr(2'd1, 8'h01);
    wr(2'd2, 8'h01);

    // R5 / R7: first timeout with code 0
    wr(2'd0, 8'h00);
    expect_vec(256);
    ticks(256);
    repeat (2) @(negedge clk);
    rd(2'd1, v); chk("R5 source flag set", v, 8'h03);
    rd(2'd2, v); chk("R5 shared flag set", v, 8'h41);
    // R7: second timeout while shared flag still set: no new request
    wr(2'd0, 8'h00);
    ticks(256);
    ticks(255);
    // R6: clear write on the timeout edge loses
    rtc_tick = 1; reg_we = 1; reg_addr = 2'd1; reg_wdata = 8'h01;
    @(negedge clk);
    rtc_tick = 0; reg_we = 0;
    rd(2'd1, v); chk("R6 timeout beats clear", v, 8'h03);
    wr(2'd1, 8'h01);
    rd(2'd1, v); chk("R6 write zero clears", v, 8'h01);
    wr(2'd1, 8'h03);
    rd(2'd1, v); chk("R6 write one no effect", v, 8'h01);
    wr(2'd2, 8'h01);
    wr(2'd2, 8'h41);
    rd(2'd2, v); chk("R6 shared write one no effect", v, 8'h01);

    // R3: every rate code, RTC source
    for (int k = 1; k < 8; k++) begin
      wr(2'd0, 8'(k));
      rd(2'd0, v); chk("R3 rate readback", v, k);
      expect_vec(1 << (8 + k));
      ticks(1 << (8 + k));
      settle_clear("R3", 8'h03, 8'h41, 8'h01, 8'h01);
    end

    // R4: partial count before a new rate write must not shorten the period
    wr(2'd0, 8'h02);
    ticks(500);
    wr(2'd0, 8'h01);
    expect_vec(512);
    ticks(512);
    settle_clear("R4", 8'h03, 8'h41, 8'h01, 8'h01);

    // R2: instruction clock source
    src_rtc = 0;
    wr(2'd0, 8'h00);
    expect_vec(1024);
    repeat (1030) @(negedge clk);
    src_rtc = 1;
    settle_clear("R2", 8'h03, 8'h41, 8'h01, 8'h01);

    // R8: stack full blocks the request
    stack_full = 1;
    wr(2'd0, 8'h00);
    ticks(256);
    stack_full = 0;
    settle_clear("R8 stack full", 8'h03, 8'h41, 8'h01, 8'h00);
    // R8: shared enable off blocks the request
    wr(2'd0, 8'h00);
    ticks(256);
    settle_clear("R8 enable off", 8'h03, 8'h40, 8'h00, 8'h00);

    // R5: timer enable off, no flags
    wr(2'd0, 8'h00);
    ticks(256);
    repeat (2) @(negedge clk);
    rd(2'd1, v); chk("R5 disabled source flag", v, 0);
    rd(2'd2, v); chk("R5 disabled shared flag", v, 0);

    // R9: tap outputs
    disp_sel = 3'd2; bz_sel = 3'd5;
    wr(2'd0, 8'h00);
    ticks(4);
    chk("R9 disp tap n=4", disp_out, 1);
    chk("R9 buzz tap n=4", bz_out, 0);
    ticks(28);
    chk("R9 disp tap n=32", disp_out, 0);
    chk("R9 buzz tap n=32", bz_out, 1);

    repeat (4) @(negedge clk);
    chk("R7 requests left in scoreboard", exp_q.size(), 0);
    chk("R7 request count", vec_seen, vec_pushed);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule